// File: doc/BRIEF.md
# Chained Floating-Point Multiply-Accumulate Datapath

This block computes dot products in a 45-bit floating-point format of its own. Each cycle it may accept two operands, as a dual-read data memory would deliver them, together with a thread number. A three-stage multiplier forms their product and truncates it to the format. The product then passes straight into a three-stage adder, which sums it with that thread's running accumulator. Four threads share the datapath. Each has its own accumulator, so interleaved threads can keep one multiply-accumulate step in flight on every cycle.

The format has no subnormals and no infinities. Every rounding drops the surplus bits, so each result moves toward zero. Results that fall below the smallest normal exponent become zero. Results that exceed the largest exponent saturate to the largest finite magnitude. A clear flag that travels with an operand pair makes the product replace the accumulator instead of adding to it. Every updated accumulator value is presented on the result port, tagged with its thread.

Top module: `fp45_mac_chain`

## Requirements
- R1: A word holds the sign at bit 44, a 9-bit exponent at bits 43:35 with bias 255, and a 34-bit fraction at bits 34:1 below an implied leading one. Bit 0 is always zero. An exponent of zero means the value zero, and zero is always produced as the all-zero word.
- R2: The product of two operands is formed exactly and then truncated to a 34-bit fraction, never rounded up.
- R3: Each result is the thread's previous accumulator plus the truncated product, truncated toward zero. This holds when opposite signs subtract magnitudes and when the smaller operand is aligned away entirely.
- R4: A result appears on `res_valid` exactly 6 clock cycles after its operand pair was accepted, and `res_tid` carries the thread number of that operand pair. A new operand pair may be accepted on every cycle.
- R5: There are four independent accumulators, one per thread, and reset sets all of them to zero.
- R6: An operand pair accepted with `in_clear` high makes the accumulator equal to its product, discarding the old value.
- R7: A result whose exponent would exceed 511 becomes exponent 511 with an all-ones fraction, keeping the correct sign.
- R8: A product or sum whose exponent would fall below 1 becomes zero, and a zero operand gives a zero product.
- R9: When a sum of opposite signs cancels exactly, the result is positive zero.
- R10: After a thread issues, it must not issue again within the next two cycles. With a spacing of three cycles, each step sees the accumulator written by the step before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_clear | input | 1 | Load the accumulator with this product instead of adding |
| in_tid | input | 2 | Thread owning this operand pair |
| in_a | input | 45 | First operand |
| in_b | input | 45 | Second operand |
| res_valid | output | 1 | Updated accumulator value present |
| res_tid | output | 2 | Thread of the result |
| res_value | output | 45 | New accumulator value |

## Verification
Two functions meet in the same cycle: the final adder stage writes one thread's accumulator while the first adder stage reads an accumulator for a later operand pair. Round-robin issue across all four threads on consecutive cycles provokes this for different threads. A single thread issuing every third cycle provokes it for the same thread, where the read must see the value written in the cycle just before. In both cases the final sums are compared with values worked out from exact operands, so a stale or misrouted accumulator shows up as a wrong total.

// File: rtl/fp45_mac_chain.sv
module fp45_mac_chain #(
  parameter int THREADS = 4,
  localparam int TW = $clog2(THREADS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_clear,
  input  logic [TW-1:0] in_tid,
  input  logic [44:0]   in_a,
  input  logic [44:0]   in_b,
  output logic          res_valid,
  output logic [TW-1:0] res_tid,
  output logic [44:0]   res_value
);

  localparam logic [33:0] ONES = '1;

  function automatic logic [34:0] signif(input logic [44:0] x);
    return (x[43:35] == 9'd0) ? 35'd0 : {1'b1, x[34:1]};
  endfunction

  logic [44:0] acc [THREADS];

  // multiply stage 1: exponent sum, significands
  logic                m1_v, m1_clr, m1_s, m1_z;
  logic [TW-1:0]       m1_tid;
  logic signed [10:0]  m1_e;
  logic [34:0]         m1_sa, m1_sb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_v <= 1'b0; m1_clr <= 1'b0; m1_s <= 1'b0; m1_z <= 1'b1;
      m1_tid <= '0; m1_e <= '0; m1_sa <= '0; m1_sb <= '0;
    end else begin
      m1_v   <= in_valid;
      m1_clr <= in_clear;
      m1_tid <= in_tid;
      m1_s   <= in_a[44] ^ in_b[44];
      m1_z   <= (in_a[43:35] == 9'd0) || (in_b[43:35] == 9'd0);
      m1_e   <= $signed({2'b0, in_a[43:35]}) + $signed({2'b0, in_b[43:35]}) - 11'sd255;
      m1_sa  <= signif(in_a);
      m1_sb  <= signif(in_b);
    end
  end

  // multiply stage 2: full product
  logic                m2_v, m2_clr, m2_s, m2_z;
  logic [TW-1:0]       m2_tid;
  logic signed [10:0]  m2_e;
  logic [69:0]         m2_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m2_v <= 1'b0; m2_clr <= 1'b0; m2_s <= 1'b0; m2_z <= 1'b1;
      m2_tid <= '0; m2_e <= '0; m2_p <= '0;
    end else begin
      m2_v   <= m1_v;
      m2_clr <= m1_clr;
      m2_tid <= m1_tid;
      m2_s   <= m1_s;
      m2_z   <= m1_z;
      m2_e   <= m1_e;
      m2_p   <= 70'(m1_sa) * 70'(m1_sb);
    end
  end

  // multiply stage 3: normalize, truncate, pack
  logic signed [10:0] pe;
  logic [33:0]        pf;
  logic [44:0]        pword;
  assign pe = m2_e + $signed({10'd0, m2_p[69]});
  assign pf = m2_p[69] ? m2_p[68:35] : m2_p[67:34];

  always_comb begin
    if (m2_z || pe < 11'sd1)  pword = '0;
    else if (pe > 11'sd511)   pword = {m2_s, 9'h1FF, ONES, 1'b0};
    else                      pword = {m2_s, pe[8:0], pf, 1'b0};
  end

  logic          m3_v, m3_clr;
  logic [TW-1:0] m3_tid;
  logic [44:0]   m3_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m3_v <= 1'b0; m3_clr <= 1'b0; m3_tid <= '0; m3_w <= '0;
    end else begin
      m3_v   <= m2_v;
      m3_clr <= m2_clr;
      m3_tid <= m2_tid;
      m3_w   <= pword;
    end
  end

  // add stage 1: pick larger magnitude, align the smaller with sticky
  logic [44:0] opd, big, sml;
  logic [8:0]  dexp;
  logic [37:0] xb, xs, xal, msk;

  assign opd  = m3_clr ? '0 : acc[m3_tid];
  assign big  = (m3_w[43:1] >= opd[43:1]) ? m3_w : opd;
  assign sml  = (m3_w[43:1] >= opd[43:1]) ? opd : m3_w;
  assign dexp = big[43:35] - sml[43:35];
  assign xb   = {signif(big), 3'b000};
  assign xs   = {signif(sml), 3'b000};

  always_comb begin
    msk = '0;
    if (dexp >= 9'd38) begin
      xal = {37'd0, |xs};
    end else begin
      msk = (38'd1 << dexp) - 38'd1;
      xal = (xs >> dexp) | {37'd0, |(xs & msk)};
    end
  end

  logic          a1_v, a1_s, a1_sub;
  logic [TW-1:0] a1_tid;
  logic [8:0]    a1_e;
  logic [37:0]   a1_big, a1_sml;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1_v <= 1'b0; a1_s <= 1'b0; a1_sub <= 1'b0; a1_tid <= '0;
      a1_e <= '0; a1_big <= '0; a1_sml <= '0;
    end else begin
      a1_v   <= m3_v;
      a1_tid <= m3_tid;
      a1_s   <= big[44];
      a1_sub <= big[44] ^ sml[44];
      a1_e   <= big[43:35];
      a1_big <= xb;
      a1_sml <= xal;
    end
  end

  // add stage 2: magnitude add or subtract
  logic          a2_v, a2_s;
  logic [TW-1:0] a2_tid;
  logic [8:0]    a2_e;
  logic [38:0]   a2_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a2_v <= 1'b0; a2_s <= 1'b0; a2_tid <= '0; a2_e <= '0; a2_sum <= '0;
    end else begin
      a2_v   <= a1_v;
      a2_tid <= a1_tid;
      a2_s   <= a1_s;
      a2_e   <= a1_e;
      a2_sum <= a1_sub ? {1'b0, a1_big} - {1'b0, a1_sml}
                       : {1'b0, a1_big} + {1'b0, a1_sml};
    end
  end

  // add stage 3: normalize, truncate, write back
  logic [5:0]         lead;
  logic [38:0]        norm;
  logic signed [10:0] se;
  logic [44:0]        sword;

  always_comb begin
    lead = '0;
    for (int i = 0; i < 39; i++)
      if (a2_sum[i]) lead = 6'(i);
  end

  assign norm = a2_sum << (6'd38 - lead);
  assign se   = $signed({2'b0, a2_e}) + $signed({5'd0, lead}) - 11'sd37;

  always_comb begin
    if (a2_sum == '0 || se < 11'sd1) sword = '0;
    else if (se > 11'sd511)          sword = {a2_s, 9'h1FF, ONES, 1'b0};
    else                             sword = {a2_s, se[8:0], norm[37:4], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) acc[t] <= '0;
      res_valid <= 1'b0;
      res_tid   <= '0;
      res_value <= '0;
    end else begin
      if (a2_v) acc[a2_tid] <= sword;
      res_valid <= a2_v;
      res_tid   <= a2_tid;
      res_value <= sword;
    end
  end

  AST_THREAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(m1_v && m1_tid == in_tid) && !(m2_v && m2_tid == in_tid)); // R10
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##6 (res_valid && res_tid == $past(in_tid, 6))); // R4
  AST_ZERO_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_value[43:35] == 9'd0) |-> res_value == '0); // R9
  AST_LOW_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !res_value[0]); // R1
  AST_PRODUCT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (m3_v && m3_w[43:35] == 9'd0) |-> m3_w == '0); // R8

endmodule

// File: tb/test_fp45_mac_chain.sv
`timescale 1ns/1ps
module test_fp45_mac_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_clear = 1'b0;
  logic [1:0]  in_tid = '0;
  logic [44:0] in_a = '0, in_b = '0;
  logic        res_valid;
  logic [1:0]  res_tid;
  logic [44:0] res_value;

  int n_chk = 0, n_bad = 0;
  logic [44:0] last [4];

  localparam logic [44:0] MAXP = {1'b0, 9'h1FF, {34{1'b1}}, 1'b0};
  localparam logic [44:0] MAXN = {1'b1, 9'h1FF, {34{1'b1}}, 1'b0};

  fp45_mac_chain i_fp45_mac_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
    .in_tid(in_tid), .in_a(in_a), .in_b(in_b),
    .res_valid(res_valid), .res_tid(res_tid), .res_value(res_value));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (res_valid) last[res_tid] = res_value;

  function automatic logic [44:0] enc(real x);
    real m;
    int e;
    logic [33:0] f;
    if (x == 0.0) return '0;
    m = (x < 0.0) ? -x : x;
    e = 255;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0)  begin m = m * 2.0; e--; end
    f = 34'(longint'((m - 1.0) * 17179869184.0));
    return {(x < 0.0), 9'(e), f, 1'b0};
  endfunction

  task automatic check(string req, logic [44:0] act, logic [44:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue_raw(int t, logic [44:0] a, logic [44:0] b, bit c);
    in_valid = 1'b1; in_tid = 2'(t); in_a = a; in_b = b; in_clear = c;
    @(negedge clk);
    in_valid = 1'b0; in_clear = 1'b0;
  endtask

  task automatic issue(int t, real a, real b, bit c);
    issue_raw(t, enc(a), enc(b), c);
  endtask

  task automatic flush();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R5 reset valid", {44'd0, res_valid}, 45'd0);
    issue(0, 1.5, 2.0, 0);
    flush();
    // 3.0 = 1.5 * 2^1: exponent 256, top fraction bit set
    check("R5 R1 acc starts at zero", last[0], {1'b0, 9'd256, 1'b1, 33'd0, 1'b0});
  endtask

  task automatic t_latency();
    issue(3, 2.0, 2.0, 1);
    repeat (4) @(negedge clk);
    check("R4 not early", {44'd0, res_valid}, 45'd0);
    @(negedge clk);
    check("R4 valid at 6", {44'd0, res_valid}, 45'd1);
    check("R4 tid", {43'd0, res_tid}, 45'd3);
    check("R4 value", res_value, enc(4.0));
    flush();
  endtask

  task automatic t_round_robin();
    issue(0, 1.5, 2.0, 1);     issue(1, -1.0, 1.0, 1);
    issue(2, 7.0, 0.125, 1);   issue(3, 100.0, 3.0, 1);
    issue(0, 0.25, -4.0, 0);   issue(1, -2.0, 2.5, 0);
    issue(2, 1024.0, 1024.0, 0); issue(3, -0.75, 8.0, 0);
    issue(0, 3.0, 3.0, 0);     issue(1, 0.5, 0.5, 0);
    issue(2, -1048576.0, 1.0, 0); issue(3, 2.0 ** -30, 1.0, 0);
    flush();
    check("R3 R5 thread0 dot", last[0], enc(11.0));
    check("R3 R5 thread1 dot", last[1], enc(-5.75));
    check("R3 R5 thread2 dot", last[2], enc(0.875));
    check("R3 thread3 aligned away", last[3], enc(294.0));
  endtask

  task automatic t_clear();
    issue(0, 5.0, 5.0, 1);
    flush();
    check("R6 clear loads product", last[0], enc(25.0));
  endtask

  task automatic t_trunc();
    // (1 + 2^-34)^2 = 1 + 2^-33 + 2^-68 -> fraction 2
    issue_raw(1, {1'b0, 9'd255, 34'd1, 1'b0}, {1'b0, 9'd255, 34'd1, 1'b0}, 1);
    flush();
    check("R2 product truncated", last[1], {1'b0, 9'd255, 34'd2, 1'b0});
    issue(2, 1.0, 1.0, 1);
    repeat (2) @(negedge clk);
    issue(2, -(2.0 ** -20), 2.0 ** -20, 0);
    flush();
    check("R3 subtract toward zero", last[2], {1'b0, 9'd254, {34{1'b1}}, 1'b0});
  endtask

  task automatic t_cancel();
    issue(1, -2.0, 1.0, 1);
    repeat (2) @(negedge clk);
    issue(1, 1.0, 2.0, 0);
    flush();
    check("R9 cancel positive zero", last[1], 45'd0);
  endtask

  task automatic t_saturate();
    issue(0, 2.0 ** 200, 2.0 ** 200, 1);
    issue(1, -(2.0 ** 200), 2.0 ** 200, 1);
    flush();
    check("R7 product overflow", last[0], MAXP);
    check("R7 negative overflow", last[1], MAXN);
    issue(0, 2.0 ** 200, 2.0 ** 200, 0);
    flush();
    check("R7 sum overflow", last[0], MAXP);
  endtask

  task automatic t_underflow();
    issue(2, 2.0 ** -200, 2.0 ** -200, 1);
    issue(3, 0.0, 5.0, 1);
    flush();
    check("R8 underflow zero", last[2], 45'd0);
    check("R8 zero operand", last[3], 45'd0);
    issue(3, 3.0, 1.0, 1);
    repeat (2) @(negedge clk);
    issue(3, 0.0, 5.0, 0);
    flush();
    check("R8 zero product adds nothing", last[3], enc(3.0));
  endtask

  task automatic t_spacing();
    issue(2, 1.0, 1.0, 1);
    repeat (2) @(negedge clk);
    issue(2, 1.0, 2.0, 0);
    repeat (2) @(negedge clk);
    issue(2, 1.0, 4.0, 0);
    flush();
    check("R10 spacing of three", last[2], enc(7.0));
  endtask

  initial begin
    #(5ns * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++) last[t] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_round_robin();
    t_clear();
    t_trunc();
    t_cancel();
    t_saturate();
    t_underflow();
    t_spacing();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule